// File: doc/BRIEF.md
# Embedded CPU Boot Sequencer

This block takes an on-board processor out of reset and confirms that its firmware came up. On a start command it holds the processor in a cold-reset phase, then adds the warm-reset bit, waits a settling interval, and then samples a 16-bit startup signature in shared memory at fixed intervals. Memory is reached through a simple synchronous read port. The block issues a one-cycle request and takes the data on the following cycle.

If the signature never appears within a bounded number of polls, the block reads a trap identifier word. It raises a timeout flag and, when the identifier matches one of two trap codes, a trapped flag. On success it raises a started flag and reports how many polls were needed. A stop command drops both reset bits and the peripheral reset word at once. All intervals are cycle-count parameters, so a system clock can stand in for the millisecond-scale delays.

Top module: `boot_seq`

## Requirements
- R1: After reset, cpu_ctl, periph_ctl, poll_count, busy, started, timeout, trapped and mem_req are all zero.
- R2: A start accepted while idle or finished sets cpu_ctl to 2'b01 (bit 0 = cold, bit 1 = warm) and periph_ctl to all ones on the start edge. cpu_ctl becomes 2'b11 exactly COLD_CYC edges later.
- R3: The first signature request (mem_req high, mem_addr = SIG_ADDR, default 0x1E) becomes visible COLD_CYC+WARM_CYC+POLL_CYC edges after the start edge. Every request lasts one cycle.
- R4: Read data arrives on the cycle after the request. The signature is mem_rdata[15:0] and the value 0x4447 means success. When the k-th poll matches, started rises and busy falls COLD_CYC+WARM_CYC+k*(POLL_CYC+2) edges after the start edge, and poll_count equals k.
- R5: Consecutive signature requests are POLL_CYC+2 cycles apart. No more than MAX_POLLS signature reads are made per sequence.
- R6: After MAX_POLLS non-matching polls, the block makes exactly one read of TRAP_ADDR (default 0x80). timeout then rises COLD_CYC+WARM_CYC+MAX_POLLS*(POLL_CYC+2)+2 edges after the start edge, with poll_count = MAX_POLLS.
- R7: trapped is set only together with timeout, and only when the 32-bit trap word equals 0x99999999 or 0x99999901.
- R8: A start pulse while busy has no effect on the timing, the reads or the result of the running sequence.
- R9: On the edge where stop is sampled, cpu_ctl and periph_ctl become zero and the block goes idle, with no further reads. Stop takes priority over a simultaneous start.
- R10: A new accepted start clears started, timeout and trapped on the start edge.
- R11: Bits 31:16 of the signature read data do not affect the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a boot sequence (ignored while busy) |
| stop | input | 1 | Halt the processor and abort the sequence |
| mem_req | output | 1 | One-cycle shared-memory read request |
| mem_addr | output | ADDR_W | Byte address of the read |
| mem_rdata | input | DATA_W | Read data, valid the cycle after mem_req |
| cpu_ctl | output | 2 | Reset control: bit 0 cold, bit 1 warm |
| periph_ctl | output | PERIPH_W | Peripheral reset control word |
| busy | output | 1 | Sequence in progress |
| started | output | 1 | Signature seen |
| timeout | output | 1 | Polls exhausted without signature |
| trapped | output | 1 | Trap identifier matched after timeout |
| poll_count | output | clog2(MAX_POLLS+1) | Polls made in the current or last sequence |

## Verification
A wrong phase state or a corrupted interval timer moves the 01-to-11 transition of cpu_ctl or the first mem_req edge. Either shift shows at the ports within one phase of the start. A poll counter that is off by one changes both the final edge of started or timeout and the reported poll_count, so each run checks edge-exact completion against a closed-form count. A bad comparison or classifier shows as a wrong flag on the very edge the sequence ends. This is swept over every success position from the first poll to the last, and over matching and non-matching trap words.

// File: rtl/boot_pkg.sv
package boot_pkg;

    localparam int DATA_W_DEF = 32;
    localparam int SIG_W      = 16;

    localparam logic [SIG_W-1:0]      SIG_OK      = 16'h4447;
    localparam logic [DATA_W_DEF-1:0] TRAP_CODE_A = 32'h9999_9999;
    localparam logic [DATA_W_DEF-1:0] TRAP_CODE_B = 32'h9999_9901;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_COLD,
        ST_WARM,
        ST_SETTLE,
        ST_SIG_REQ,
        ST_SIG_WAIT,
        ST_TRAP_REQ,
        ST_TRAP_WAIT,
        ST_DONE
    } boot_state_t;

    typedef struct packed {
        logic warm;
        logic cold;
    } cpu_ctl_t;

    typedef struct packed {
        logic started;
        logic timeout;
        logic trapped;
    } boot_flags_t;

    function automatic logic [SIG_W-1:0] sig_field(input logic [DATA_W_DEF-1:0] w);
        return w[SIG_W-1:0];
    endfunction

    function automatic logic is_running(input boot_state_t s);
        return (s != ST_IDLE) && (s != ST_DONE);
    endfunction

endpackage

// File: rtl/boot_timer.sv
module boot_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic          en,
    output logic          zero
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (en && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/boot_poll_ctr.sv
module boot_poll_ctr #(
    parameter int MAX_POLLS = 300,
    parameter int PCW       = $clog2(MAX_POLLS + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           inc,
    output logic [PCW-1:0] count,
    output logic           last
);
    localparam logic [PCW-1:0] LIMIT = PCW'(MAX_POLLS);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc && (count != LIMIT)) begin
            count <= count + 1'b1;
        end
    end

    assign last = (count == LIMIT);
endmodule

// File: rtl/boot_match.sv
module boot_match #(
    parameter int DATA_W = 32,
    parameter int SIG_W  = 16,
    parameter logic [SIG_W-1:0] SIG_VALUE = 16'h4447,
    parameter int NCODE  = 2,
    parameter logic [DATA_W-1:0] CODES [NCODE] = '{32'h9999_9999, 32'h9999_9901}
) (
    input  logic [DATA_W-1:0] rdata,
    output logic              sig_hit,
    output logic              trap_hit
);
    logic [NCODE-1:0] code_eq;

    generate
        for (genvar g = 0; g < NCODE; g++) begin : g_code
            assign code_eq[g] = (rdata == CODES[g]);
        end
    endgenerate

    assign sig_hit  = (rdata[SIG_W-1:0] == SIG_VALUE);
    assign trap_hit = |code_eq;
endmodule

// File: rtl/boot_seq.sv
module boot_seq
    import boot_pkg::*;
#(
    parameter int COLD_CYC  = 20,
    parameter int WARM_CYC  = 100,
    parameter int POLL_CYC  = 100,
    parameter int MAX_POLLS = 300,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = DATA_W_DEF,
    parameter int PERIPH_W  = 4,
    parameter logic [ADDR_W-1:0] SIG_ADDR  = 8'h1E,
    parameter logic [ADDR_W-1:0] TRAP_ADDR = 8'h80
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               start,
    input  logic                               stop,
    output logic                               mem_req,
    output logic [ADDR_W-1:0]                  mem_addr,
    input  logic [DATA_W-1:0]                  mem_rdata,
    output logic [1:0]                         cpu_ctl,
    output logic [PERIPH_W-1:0]                periph_ctl,
    output logic                               busy,
    output logic                               started,
    output logic                               timeout,
    output logic                               trapped,
    output logic [$clog2(MAX_POLLS+1)-1:0]     poll_count
);
    localparam int MAX_PHASE = (COLD_CYC > WARM_CYC) ?
                               ((COLD_CYC > POLL_CYC) ? COLD_CYC : POLL_CYC) :
                               ((WARM_CYC > POLL_CYC) ? WARM_CYC : POLL_CYC);
    localparam int TW  = $clog2(MAX_PHASE + 1);
    localparam int PCW = $clog2(MAX_POLLS + 1);
    localparam logic [TW-1:0] COLD_LD = TW'(COLD_CYC - 1);
    localparam logic [TW-1:0] WARM_LD = TW'(WARM_CYC - 1);
    localparam logic [TW-1:0] POLL_LD = TW'(POLL_CYC - 1);
    localparam logic [DATA_W-1:0] CODE_LIST [2] = '{DATA_W'(TRAP_CODE_A), DATA_W'(TRAP_CODE_B)};

    boot_state_t          state;
    cpu_ctl_t             ctl_q;
    boot_flags_t          flags_q;
    logic [PERIPH_W-1:0]  periph_q;

    logic                 accept;
    logic                 tmr_load;
    logic [TW-1:0]        tmr_val;
    logic                 tmr_en;
    logic                 tmr_zero;
    logic                 poll_inc;
    logic                 poll_last;
    logic [PCW-1:0]       poll_cnt;
    logic                 sig_hit;
    logic                 trap_hit;

    assign accept = start && !stop && !is_running(state);

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (!stop) begin
            case (state)
                ST_IDLE, ST_DONE: if (start) begin
                    tmr_load = 1'b1;
                    tmr_val  = COLD_LD;
                end
                ST_COLD: if (tmr_zero) begin
                    tmr_load = 1'b1;
                    tmr_val  = WARM_LD;
                end
                ST_WARM: if (tmr_zero) begin
                    tmr_load = 1'b1;
                    tmr_val  = POLL_LD;
                end
                ST_SIG_WAIT: if (!sig_hit && !poll_last) begin
                    tmr_load = 1'b1;
                    tmr_val  = POLL_LD;
                end
                default: ;
            endcase
        end
    end

    assign tmr_en   = (state == ST_COLD) || (state == ST_WARM) || (state == ST_SETTLE);
    assign poll_inc = (state == ST_SIG_REQ) && !stop;

    boot_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .en       (tmr_en),
        .zero     (tmr_zero)
    );

    boot_poll_ctr #(.MAX_POLLS(MAX_POLLS), .PCW(PCW)) u_polls (
        .clk   (clk),
        .rst   (rst),
        .clr   (accept),
        .inc   (poll_inc),
        .count (poll_cnt),
        .last  (poll_last)
    );

    boot_match #(
        .DATA_W    (DATA_W),
        .SIG_W     (SIG_W),
        .SIG_VALUE (SIG_OK),
        .NCODE     (2),
        .CODES     (CODE_LIST)
    ) u_match (
        .rdata    (mem_rdata),
        .sig_hit  (sig_hit),
        .trap_hit (trap_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            ctl_q    <= '0;
            periph_q <= '0;
            flags_q  <= '0;
        end else if (stop) begin
            state    <= ST_IDLE;
            ctl_q    <= '0;
            periph_q <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        state      <= ST_COLD;
                        ctl_q.cold <= 1'b1;
                        ctl_q.warm <= 1'b0;
                        periph_q   <= '1;
                        flags_q    <= '0;
                    end
                end
                ST_COLD: begin
                    if (tmr_zero) begin
                        state      <= ST_WARM;
                        ctl_q.warm <= 1'b1;
                    end
                end
                ST_WARM: begin
                    if (tmr_zero) state <= ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (tmr_zero) state <= ST_SIG_REQ;
                end
                ST_SIG_REQ: begin
                    state <= ST_SIG_WAIT;
                end
                ST_SIG_WAIT: begin
                    if (sig_hit) begin
                        state           <= ST_DONE;
                        flags_q.started <= 1'b1;
                    end else if (poll_last) begin
                        state <= ST_TRAP_REQ;
                    end else begin
                        state <= ST_SETTLE;
                    end
                end
                ST_TRAP_REQ: begin
                    state <= ST_TRAP_WAIT;
                end
                ST_TRAP_WAIT: begin
                    state           <= ST_DONE;
                    flags_q.timeout <= 1'b1;
                    flags_q.trapped <= trap_hit;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mem_req    = (state == ST_SIG_REQ) || (state == ST_TRAP_REQ);
    assign mem_addr   = (state == ST_TRAP_REQ) ? TRAP_ADDR : SIG_ADDR;
    assign cpu_ctl    = ctl_q;
    assign periph_ctl = periph_q;
    assign busy       = is_running(state);
    assign started    = flags_q.started;
    assign timeout    = flags_q.timeout;
    assign trapped    = flags_q.trapped;
    assign poll_count = poll_cnt;
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk #(
    parameter int MAX_POLLS = 300,
    parameter int ADDR_W    = 8,
    parameter int PERIPH_W  = 4,
    parameter logic [ADDR_W-1:0] SIG_ADDR  = 8'h1E,
    parameter logic [ADDR_W-1:0] TRAP_ADDR = 8'h80
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           stop,
    input logic                           mem_req,
    input logic [ADDR_W-1:0]              mem_addr,
    input logic [1:0]                     cpu_ctl,
    input logic [PERIPH_W-1:0]            periph_ctl,
    input logic                           busy,
    input logic                           started,
    input logic                           timeout,
    input logic                           trapped,
    input logic [$clog2(MAX_POLLS+1)-1:0] poll_count
);
    // R2: warm bit never set without the cold bit
    a_r2_cold_before_warm: assert property (@(posedge clk) disable iff (rst)
        cpu_ctl != 2'b10);

    // R3: a request lasts exactly one cycle
    a_r3_single_cycle_req: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R3, R6: only the two defined addresses are read
    a_r3_req_addr: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr == SIG_ADDR || mem_addr == TRAP_ADDR));

    // R5: poll count bounded
    a_r5_poll_bound: assert property (@(posedge clk) disable iff (rst)
        poll_count <= ($clog2(MAX_POLLS+1))'(MAX_POLLS));

    // R6: success and timeout exclusive
    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(started && timeout));

    // R7: trapped only with timeout
    a_r7_trap_needs_timeout: assert property (@(posedge clk) disable iff (rst)
        trapped |-> timeout);

    // R9: stop clears control words and idles the block
    a_r9_stop_clears: assert property (@(posedge clk) disable iff (rst)
        stop |=> (cpu_ctl == 2'b00 && periph_ctl == '0 && !busy && !mem_req));
endmodule

bind boot_seq boot_seq_chk #(
    .MAX_POLLS (MAX_POLLS),
    .ADDR_W    (ADDR_W),
    .PERIPH_W  (PERIPH_W),
    .SIG_ADDR  (SIG_ADDR),
    .TRAP_ADDR (TRAP_ADDR)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .stop       (stop),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .cpu_ctl    (cpu_ctl),
    .periph_ctl (periph_ctl),
    .busy       (busy),
    .started    (started),
    .timeout    (timeout),
    .trapped    (trapped),
    .poll_count (poll_count)
);

// File: tb/tb_boot_seq.sv
module tb_boot_seq;
    localparam int CLK_PERIOD = 10;
    localparam int C  = 3;
    localparam int W  = 5;
    localparam int P  = 4;
    localparam int M  = 6;
    localparam int PCW = $clog2(M + 1);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic           stop = 1'b0;
    logic           mem_req;
    logic [7:0]     mem_addr;
    logic [31:0]    mem_rdata = '0;
    logic [1:0]     cpu_ctl;
    logic [3:0]     periph_ctl;
    logic           busy, started, timeout, trapped;
    logic [PCW-1:0] poll_count;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    int          k_ok = 0;
    logic [31:0] trap_val = '0;
    logic [15:0] hi_bits = '0;
    int          sig_rd_n = 0;
    int          trap_rd_n = 0;
    int          g1 = -1;
    int          g2 = -1;

    boot_seq #(
        .COLD_CYC(C), .WARM_CYC(W), .POLL_CYC(P), .MAX_POLLS(M),
        .ADDR_W(8), .DATA_W(32), .PERIPH_W(4),
        .SIG_ADDR(8'h1E), .TRAP_ADDR(8'h80)
    ) dut (
        .clk(clk), .rst(rst), .start(start), .stop(stop),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .cpu_ctl(cpu_ctl), .periph_ctl(periph_ctl), .busy(busy),
        .started(started), .timeout(timeout), .trapped(trapped),
        .poll_count(poll_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // shared memory model: data one cycle after the request
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_addr == 8'h1E) begin
                sig_rd_n = sig_rd_n + 1;
                mem_rdata <= {hi_bits, (sig_rd_n == k_ok) ? 16'h4447 : 16'h4446};
            end else if (mem_addr == 8'h80) begin
                trap_rd_n = trap_rd_n + 1;
                mem_rdata <= trap_val;
            end else begin
                mem_rdata <= 32'h0;
            end
        end
    end

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // one full sequence; k = success poll (0 = never)
    task automatic run(input int k, input logic [31:0] tv, input logic [15:0] hb);
        int t0, d, d_warm, d_req, d_done, exp_done;
        k_ok = k; trap_val = tv; hi_bits = hb; sig_rd_n = 0; trap_rd_n = 0;
        @(negedge clk); start = 1'b1; t0 = cyc;
        @(negedge clk); start = 1'b0;
        chk(cpu_ctl == 2'b01, "R2 cold only", cpu_ctl, 1);
        chk(periph_ctl == 4'hF, "R2 periph on", periph_ctl, 15);
        chk(!started && !timeout && !trapped, "R10 flags cleared",
            {started, timeout, trapped}, 0);
        d_warm = -1; d_req = -1; d_done = -1;
        for (int i = 0; i < 1000; i++) begin
            d = cyc - t0 - 1;
            if (d_warm < 0 && cpu_ctl == 2'b11) d_warm = d;
            if (d_req < 0 && mem_req) d_req = d;
            if (started || timeout) begin d_done = d; break; end
            @(negedge clk);
            start = ((cyc - t0 - 1) == g1) || ((cyc - t0 - 1) == g2);
        end
        start = 1'b0;
        chk(d_warm == C, "R2 warm edge", d_warm, C);
        chk(d_req == C + W + P, "R3 first request", d_req, C + W + P);
        if (k > 0 && k <= M) begin
            exp_done = C + W + k * (P + 2);
            chk(d_done == exp_done, "R4 success edge", d_done, exp_done);
            chk(started && !timeout && !trapped && !busy, "R4 flags",
                {started, timeout, trapped, busy}, 4'b1000);
            chk(poll_count == PCW'(k), "R4 poll count", poll_count, k);
            chk(sig_rd_n == k && trap_rd_n == 0, "R5 read count", sig_rd_n, k);
        end else begin
            exp_done = C + W + M * (P + 2) + 2;
            chk(d_done == exp_done, "R6 timeout edge", d_done, exp_done);
            chk(timeout && !started && !busy, "R6 flags",
                {started, timeout, busy}, 3'b010);
            chk(poll_count == PCW'(M), "R6 poll count", poll_count, M);
            chk(sig_rd_n == M && trap_rd_n == 1, "R6 reads", {sig_rd_n, trap_rd_n}, {M, 1});
            chk(trapped == (tv == 32'h9999_9999 || tv == 32'h9999_9901),
                "R7 trap classify", trapped, (tv == 32'h9999_9999 || tv == 32'h9999_9901));
        end
        chk(cpu_ctl == 2'b11, "R2 cpu running after sequence", cpu_ctl, 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cpu_ctl == 0 && periph_ctl == 0 && !busy && !mem_req, "R1 reset ctl",
            {cpu_ctl, periph_ctl, busy, mem_req}, 0);
        chk(!started && !timeout && !trapped && poll_count == 0, "R1 reset flags",
            {started, timeout, trapped, poll_count}, 0);
        rst = 1'b0;
        @(negedge clk);

        // R4/R5 sweep of every success position
        for (int k = 1; k <= M; k++) run(k, 32'h0, 16'h0);
        // R11 upper halfword ignored on success and on a miss
        run(2, 32'h0, 16'hABCD);
        run(M, 32'h0, 16'h4447);
        // R6/R7 timeouts with different trap words
        run(0, 32'h9999_9999, 16'h0);
        run(0, 32'h9999_9901, 16'h0);
        run(0, 32'h9999_9900, 16'h0);
        run(0, 32'h0000_0000, 16'h0);
        // R10 restart after timeout
        run(1, 32'h0, 16'h0);

        // R8 start pulses while busy
        g1 = 1; g2 = C + W + P + 1;
        run(3, 32'h0, 16'h0);
        g1 = C + W + 2 * (P + 2); g2 = -1;
        run(0, 32'h9999_9901, 16'h0);
        g1 = -1; g2 = -1;

        // R9 stop mid-sequence
        sig_rd_n = 0; trap_rd_n = 0; k_ok = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (C + W + P + 1) @(negedge clk);
        stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        chk(cpu_ctl == 0 && periph_ctl == 0 && !busy, "R9 stop clears",
            {cpu_ctl, periph_ctl, busy}, 0);
        begin
            int reqs = 0;
            for (int i = 0; i < 3 * (P + 2); i++) begin
                if (mem_req) reqs++;
                @(negedge clk);
            end
            chk(reqs == 0 && sig_rd_n == 1, "R9 no reads after stop", reqs, 0);
        end
        // R9 stop wins over start
        start = 1'b1; stop = 1'b1;
        @(negedge clk); start = 1'b0; stop = 1'b0;
        chk(!busy && cpu_ctl == 0 && periph_ctl == 0, "R9 stop priority",
            {busy, cpu_ctl, periph_ctl}, 0);

        finish_run();
    end
endmodule